// File: doc/BRIEF.md
# TDM ISDN Frame Serializer/Deserializer

This block terminates a four-wire time-division-multiplexed ISDN line: a data clock, an 8 kHz frame sync, a serial input carrying downstream bits and a serial output carrying upstream bits. A frame lasts 125 µs and is cut into 32-bit channel slots, and the data clock runs at twice the bit rate. The block is clocked directly by the data clock. It samples incoming bits on odd-numbered rising edges, counted from the edge that detects the frame sync. It launches outgoing bits on even-numbered edges, so the far end sees them stable when it samples on the odd ones.

Each slot carries two B octets, a monitor octet, two D bits, a four-bit C/I code and the MR and MX handshake bits. The transmit side takes these fields per slot on parallel inputs and latches them at the start of a frame. The receive side gathers the incoming fields of every active slot and presents them on parallel outputs, together with a one-cycle frame-done strobe. Both the number of slots per frame and the number of active slots are parameters. A frame sync that arrives at the wrong time, or fails to arrive, is flagged. The block then realigns to the sync it sees.

Top module: `iom_serdes`

## Requirements
- R1: While `rst_n` is low, `dout` is 1, `frame_done` and `sync_err` are 0, and every receive field output is 0.
- R2: A rising edge of `fsync` is detected on the clock edge where `fsync` is 1 and was 0 at the previous edge. Counting that edge as edge 0, serial bit k of the frame is sampled from `din` at edge 2k+1.
- R3: Slot s covers frame bits 32s to 32s+31, sent MSB first in this order: B1[7:0], B2[7:0], monitor[7:0], D[1:0], C/I[3:0], MR, MX. On every per-slot field port, slot s sits at `[s*W +: W]`, where W is the width of the field.
- R4: `dout` changes only on even edges. Bit k is driven at edge 2k and holds across edge 2k+1.
- R5: The transmit field inputs are latched at the frame-start edge. Changing them later in the frame does not affect that frame's serial output.
- R6: Bits beyond the last active slot (bit index 32*ACTIVE_SLOTS and up) are driven as 1.
- R7: The receive outputs change only together with `frame_done`, a one-cycle pulse set by the edge that samples the last bit of the last active slot (edge 64*ACTIVE_SLOTS-1).
- R8: If a sync edge is detected anywhere other than the expected frame boundary (edge 64*FRAME_SLOTS after the previous start), `sync_err` pulses for one cycle after that edge. The bit count then restarts from the new sync.
- R9: If no sync edge is detected at the expected frame boundary, `sync_err` pulses for one cycle after that edge. The frame counter wraps on its own, and transmission and reception continue on the old timing.
- R10: Until the first sync edge after reset, `dout` stays 1 and `frame_done` stays 0. The first sync edge raises no `sync_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Data clock, twice the bit rate; all logic uses its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | 8 kHz frame sync |
| din | input | 1 | Serial downstream data |
| dout | output | 1 | Serial upstream data |
| tx_b1 | input | 8*ACTIVE_SLOTS | First B octet per slot |
| tx_b2 | input | 8*ACTIVE_SLOTS | Second B octet per slot |
| tx_mon | input | 8*ACTIVE_SLOTS | Monitor octet per slot |
| tx_d | input | 2*ACTIVE_SLOTS | D bits per slot |
| tx_ci | input | 4*ACTIVE_SLOTS | C/I code per slot |
| tx_mr | input | ACTIVE_SLOTS | MR bit per slot |
| tx_mx | input | ACTIVE_SLOTS | MX bit per slot |
| rx_b1 | output | 8*ACTIVE_SLOTS | Received first B octet per slot |
| rx_b2 | output | 8*ACTIVE_SLOTS | Received second B octet per slot |
| rx_mon | output | 8*ACTIVE_SLOTS | Received monitor octet per slot |
| rx_d | output | 2*ACTIVE_SLOTS | Received D bits per slot |
| rx_ci | output | 4*ACTIVE_SLOTS | Received C/I code per slot |
| rx_mr | output | ACTIVE_SLOTS | Received MR bit per slot |
| rx_mx | output | ACTIVE_SLOTS | Received MX bit per slot |
| frame_done | output | 1 | One-cycle strobe when the receive outputs update |
| sync_err | output | 1 | One-cycle pulse on a misplaced or missing frame sync |

## Verification
The assertions assume that `fsync` changes only between rising edges of `dclk`, so each sync edge is seen on exactly one clock edge. They also assume the sync pulse stays low for at least one edge before each rise. The bench drives `fsync`, `din` and the transmit fields only on falling edges, and holds the sync high for two edges per frame. It places misplaced and missing syncs at exact edge counts, so the expected error cycle is known in advance.

// File: rtl/iom_pkg.sv
package iom_pkg;

  localparam int SLOT_BITS = 32;

  typedef struct packed {
    logic [7:0] b1;
    logic [7:0] b2;
    logic [7:0] mon;
    logic [1:0] d;
    logic [3:0] ci;
    logic       mr;
    logic       mx;
  } slot_t;

  function automatic int frame_edges(input int slots);
    return 2 * slots * SLOT_BITS;
  endfunction

  function automatic int edge_cnt_width(input int slots);
    return $clog2(frame_edges(slots));
  endfunction

  function automatic logic [SLOT_BITS-1:0] pack_slot(
    input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] mon,
    input logic [1:0] d, input logic [3:0] ci, input logic mr, input logic mx);
    slot_t s;
    s.b1 = b1; s.b2 = b2; s.mon = mon; s.d = d; s.ci = ci; s.mr = mr; s.mx = mx;
    return s;
  endfunction

endpackage

// File: rtl/iom_timing.sv
module iom_timing #(
  parameter int FRAME_SLOTS  = 8,
  parameter int ACTIVE_SLOTS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync,
  output logic locked,
  output logic frame_start,
  output logic rx_en,
  output logic rx_last,
  output logic tx_step,
  output logic tx_in_range,
  output logic sync_err
);
  localparam int EDGES = iom_pkg::frame_edges(FRAME_SLOTS);
  localparam int EW    = iom_pkg::edge_cnt_width(FRAME_SLOTS);
  localparam int AB    = ACTIVE_SLOTS * iom_pkg::SLOT_BITS;

  logic          fs_q;
  logic [EW-1:0] ecnt;
  logic          detect;
  logic          at_end;
  logic [EW-2:0] bit_idx;

  assign detect      = fsync & ~fs_q;
  assign at_end      = (ecnt == EW'(EDGES - 1));
  assign bit_idx     = ecnt[EW-1:1];
  assign frame_start = detect | (locked & at_end);
  assign rx_en       = locked & ~detect & ~ecnt[0] & (int'(bit_idx) < AB);
  assign rx_last     = rx_en & (int'(bit_idx) == AB - 1);
  assign tx_step     = locked & ~frame_start & ecnt[0];
  assign tx_in_range = (int'(bit_idx) + 1) < AB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q     <= 1'b1;
      ecnt     <= '0;
      locked   <= 1'b0;
      sync_err <= 1'b0;
    end else begin
      fs_q <= fsync;
      if (detect) begin
        ecnt     <= '0;
        locked   <= 1'b1;
        sync_err <= locked & ~at_end;
      end else if (locked) begin
        if (at_end) begin
          ecnt     <= '0;
          sync_err <= 1'b1;
        end else begin
          ecnt     <= ecnt + 1'b1;
          sync_err <= 1'b0;
        end
      end else begin
        sync_err <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/iom_tx.sv
module iom_tx #(
  parameter int ACTIVE_BITS = 128
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_start,
  input  logic                   tx_step,
  input  logic                   tx_in_range,
  input  logic [ACTIVE_BITS-1:0] load_word,
  output logic                   dout
);
  logic [ACTIVE_BITS-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      dout <= 1'b1;
    end else if (frame_start) begin
      dout <= load_word[ACTIVE_BITS-1];
      sr   <= load_word << 1;
    end else if (tx_step) begin
      if (tx_in_range) begin
        dout <= sr[ACTIVE_BITS-1];
        sr   <= sr << 1;
      end else begin
        dout <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/iom_rx.sv
module iom_rx #(
  parameter int ACTIVE_BITS = 128
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_en,
  input  logic                   rx_last,
  input  logic                   din,
  output logic [ACTIVE_BITS-1:0] rx_word,
  output logic                   frame_done
);
  logic [ACTIVE_BITS-1:0] sr;
  logic [ACTIVE_BITS-1:0] sr_next;

  assign sr_next = {sr[ACTIVE_BITS-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr         <= '0;
      rx_word    <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= rx_last;
      if (rx_en) sr <= sr_next;
      if (rx_last) rx_word <= sr_next;
    end
  end
endmodule

// File: rtl/iom_serdes.sv
module iom_serdes #(
  parameter int FRAME_SLOTS  = 8,
  parameter int ACTIVE_SLOTS = 4
) (
  input  logic                      dclk,
  input  logic                      rst_n,
  input  logic                      fsync,
  input  logic                      din,
  output logic                      dout,
  input  logic [8*ACTIVE_SLOTS-1:0] tx_b1,
  input  logic [8*ACTIVE_SLOTS-1:0] tx_b2,
  input  logic [8*ACTIVE_SLOTS-1:0] tx_mon,
  input  logic [2*ACTIVE_SLOTS-1:0] tx_d,
  input  logic [4*ACTIVE_SLOTS-1:0] tx_ci,
  input  logic [ACTIVE_SLOTS-1:0]   tx_mr,
  input  logic [ACTIVE_SLOTS-1:0]   tx_mx,
  output logic [8*ACTIVE_SLOTS-1:0] rx_b1,
  output logic [8*ACTIVE_SLOTS-1:0] rx_b2,
  output logic [8*ACTIVE_SLOTS-1:0] rx_mon,
  output logic [2*ACTIVE_SLOTS-1:0] rx_d,
  output logic [4*ACTIVE_SLOTS-1:0] rx_ci,
  output logic [ACTIVE_SLOTS-1:0]   rx_mr,
  output logic [ACTIVE_SLOTS-1:0]   rx_mx,
  output logic                      frame_done,
  output logic                      sync_err
);
  localparam int SB = iom_pkg::SLOT_BITS;
  localparam int AB = ACTIVE_SLOTS * SB;

  logic          tm_locked;
  logic          tm_frame_start;
  logic          tm_rx_en;
  logic          tm_rx_last;
  logic          tm_tx_step;
  logic          tm_tx_in_range;
  logic [AB-1:0] tx_word;
  logic [AB-1:0] rx_word;

  iom_timing #(.FRAME_SLOTS(FRAME_SLOTS), .ACTIVE_SLOTS(ACTIVE_SLOTS)) u_timing (
    .clk(dclk), .rst_n(rst_n), .fsync(fsync),
    .locked(tm_locked), .frame_start(tm_frame_start),
    .rx_en(tm_rx_en), .rx_last(tm_rx_last),
    .tx_step(tm_tx_step), .tx_in_range(tm_tx_in_range),
    .sync_err(sync_err)
  );

  iom_tx #(.ACTIVE_BITS(AB)) u_tx (
    .clk(dclk), .rst_n(rst_n), .frame_start(tm_frame_start),
    .tx_step(tm_tx_step), .tx_in_range(tm_tx_in_range),
    .load_word(tx_word), .dout(dout)
  );

  iom_rx #(.ACTIVE_BITS(AB)) u_rx (
    .clk(dclk), .rst_n(rst_n), .rx_en(tm_rx_en), .rx_last(tm_rx_last),
    .din(din), .rx_word(rx_word), .frame_done(frame_done)
  );

  for (genvar s = 0; s < ACTIVE_SLOTS; s++) begin : g_slot
    iom_pkg::slot_t rs;
    assign tx_word[AB-1-SB*s -: SB] = iom_pkg::pack_slot(
      tx_b1[s*8 +: 8], tx_b2[s*8 +: 8], tx_mon[s*8 +: 8],
      tx_d[s*2 +: 2], tx_ci[s*4 +: 4], tx_mr[s], tx_mx[s]);
    assign rs               = rx_word[AB-1-SB*s -: SB];
    assign rx_b1[s*8 +: 8]  = rs.b1;
    assign rx_b2[s*8 +: 8]  = rs.b2;
    assign rx_mon[s*8 +: 8] = rs.mon;
    assign rx_d[s*2 +: 2]   = rs.d;
    assign rx_ci[s*4 +: 4]  = rs.ci;
    assign rx_mr[s]         = rs.mr;
    assign rx_mx[s]         = rs.mx;
  end
endmodule

// File: rtl/iom_serdes_chk.sv
module iom_serdes_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dout,
  input logic         frame_done,
  input logic         sync_err,
  input logic         locked,
  input logic         rx_en,
  input logic [W-1:0] rx_b1,
  input logic [W-1:0] rx_mon
);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> ($stable(rx_b1) && $stable(rx_mon)));

  assert_done_after_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(rx_en));

  assert_dout_odd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |=> $stable(dout));

  assert_idle_prelock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (dout && !frame_done));

  assert_err_needs_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> $past(locked));
endmodule

bind iom_serdes iom_serdes_chk #(.W(8*ACTIVE_SLOTS)) u_chk (
  .clk(dclk), .rst_n(rst_n), .dout(dout), .frame_done(frame_done),
  .sync_err(sync_err), .locked(tm_locked), .rx_en(tm_rx_en),
  .rx_b1(rx_b1), .rx_mon(rx_mon)
);

// File: tb/iom_serdes_bench.sv
module iom_serdes_bench;
  localparam int FS = 8;
  localparam int NS = 4;
  localparam int AB = NS * 32;
  localparam int FE = 2 * FS * 32;

  logic dclk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 1'b0;
  logic din = 1'b0;
  logic dout;
  logic [8*NS-1:0] tx_b1 = '0, tx_b2 = '0, tx_mon = '0;
  logic [2*NS-1:0] tx_d = '0;
  logic [4*NS-1:0] tx_ci = '0;
  logic [NS-1:0]   tx_mr = '0, tx_mx = '0;
  logic [8*NS-1:0] rx_b1, rx_b2, rx_mon;
  logic [2*NS-1:0] rx_d;
  logic [4*NS-1:0] rx_ci;
  logic [NS-1:0]   rx_mr, rx_mx;
  logic frame_done, sync_err;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rxw [NS];
  logic [31:0] txw [NS];
  logic [AB-1:0] prev_rx = '0;

  // rx seed in the upper half, tx seed in the lower half
  localparam logic [63:0] VECS [6] = '{
    64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000,
    64'h1234_5678_9ABC_DEF0, 64'hA5A5_5A5A_0F0F_F0F0,
    64'hDEAD_BEEF_0BAD_F00D, 64'h8000_0001_7FFF_FFFE};

  iom_serdes #(.FRAME_SLOTS(FS), .ACTIVE_SLOTS(NS)) u_iom_serdes (
    .dclk(dclk), .rst_n(rst_n), .fsync(fsync), .din(din), .dout(dout),
    .tx_b1(tx_b1), .tx_b2(tx_b2), .tx_mon(tx_mon), .tx_d(tx_d),
    .tx_ci(tx_ci), .tx_mr(tx_mr), .tx_mx(tx_mx),
    .rx_b1(rx_b1), .rx_b2(rx_b2), .rx_mon(rx_mon), .rx_d(rx_d),
    .rx_ci(rx_ci), .rx_mr(rx_mr), .rx_mx(rx_mx),
    .frame_done(frame_done), .sync_err(sync_err));

  always #4 dclk = ~dclk;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  task automatic chk(input bit ok, input string req, input logic [AB-1:0] act, input logic [AB-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] gen(input logic [31:0] seed, input int s);
    if (seed == 32'h0 || seed == 32'hFFFF_FFFF) return seed;
    return (seed * (s + 3)) ^ {seed[15:0], seed[31:16]} ^ (32'h5A3C_96E1 >> s);
  endfunction

  // slot word layout per R3: b1[31:24] b2[23:16] mon[15:8] d[7:6] ci[5:2] mr[1] mx[0]
  task automatic drive_tx(input bit inv);
    for (int s = 0; s < NS; s++) begin
      logic [31:0] w;
      w = inv ? ~txw[s] : txw[s];
      tx_b1[s*8 +: 8]  = w[31:24];
      tx_b2[s*8 +: 8]  = w[23:16];
      tx_mon[s*8 +: 8] = w[15:8];
      tx_d[s*2 +: 2]   = w[7:6];
      tx_ci[s*4 +: 4]  = w[5:2];
      tx_mr[s]         = w[1];
      tx_mx[s]         = w[0];
    end
  endtask

  function automatic logic [AB-1:0] exp_rx();
    logic [8*NS-1:0] e1, e2, em;
    logic [2*NS-1:0] ed;
    logic [4*NS-1:0] ec;
    logic [NS-1:0]   er, ex;
    for (int s = 0; s < NS; s++) begin
      e1[s*8 +: 8] = rxw[s][31:24];
      e2[s*8 +: 8] = rxw[s][23:16];
      em[s*8 +: 8] = rxw[s][15:8];
      ed[s*2 +: 2] = rxw[s][7:6];
      ec[s*4 +: 4] = rxw[s][5:2];
      er[s]        = rxw[s][1];
      ex[s]        = rxw[s][0];
    end
    return {e1, e2, em, ed, ec, er, ex};
  endfunction

  function automatic logic [AB-1:0] act_rx();
    return {rx_b1, rx_b2, rx_mon, rx_d, rx_ci, rx_mr, rx_mx};
  endfunction

  task automatic set_words(input logic [63:0] v);
    for (int s = 0; s < NS; s++) begin
      rxw[s] = gen(v[63:32], s);
      txw[s] = gen(v[31:0], s);
    end
  endtask

  // c counts edges from the frame start edge; the negedge at index c precedes edge c
  task automatic run_frame(input bit give_sync, input bit exp_err, input int ncyc, input string tag);
    int dones = 0;
    int errs = 0;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge dclk);
      if (c == 0) drive_tx(1'b0);
      if (c == 3) drive_tx(1'b1);  // R5: late change must not reach this frame
      fsync = give_sync && (c < 2);
      if (c == 1)
        chk(sync_err == exp_err, exp_err ? "R8/R9 sync_err pulse" : "R8 no sync_err",
            AB'(sync_err), AB'(exp_err));
      else if (c > 1 && sync_err) errs++;
      if (c >= 1 && frame_done) dones++;
      if (c[0]) begin
        int k;
        logic eb;
        k = (c - 1) / 2;
        din = (k < AB) ? rxw[k/32][31 - k%32] : k[0];
        eb = (k < AB) ? txw[k/32][31 - k%32] : 1'b1;
        chk(dout == eb, (k < AB) ? "R3/R4/R5 dout bit" : "R6 idle bit", AB'(dout), AB'(eb));
      end
      if (c == 2 * AB) begin
        chk(frame_done == 1'b1, "R7 frame_done timing", AB'(frame_done), AB'(1));
        chk(act_rx() == exp_rx(), {"R2/R3 rx fields ", tag}, act_rx(), exp_rx());
        prev_rx = exp_rx();
      end
    end
    chk(dones == ((ncyc > 2 * AB) ? 1 : 0), "R7 one strobe per frame", AB'(dones), AB'((ncyc > 2 * AB) ? 1 : 0));
    chk(errs == 0, "R8 no extra sync_err", AB'(errs), AB'(0));
  endtask

  initial begin
    repeat (3) @(negedge dclk);
    chk(dout == 1'b1 && !frame_done && !sync_err, "R1 reset outputs",
        AB'({dout, frame_done, sync_err}), AB'(3'b100));
    chk(act_rx() == '0, "R1 reset rx fields", act_rx(), '0);
    rst_n = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge dclk);
      din = c[0];
      chk(dout == 1'b1 && !frame_done, "R10 idle before lock",
          AB'({dout, frame_done}), AB'(2'b10));
    end
    // vector table: first frame also covers R10 (no error on first sync)
    for (int i = 0; i < 6; i++) begin
      set_words(VECS[i]);
      run_frame(1'b1, 1'b0, FE, $sformatf("vec%0d", i));
    end
    // R8: early sync after 100 edges
    set_words(64'h0F1E_2D3C_4B5A_6978);
    run_frame(1'b1, 1'b0, 100, "partial");
    chk(act_rx() == prev_rx, "R7 rx held on partial frame", act_rx(), prev_rx);
    set_words(64'h1357_9BDF_2468_ACE0);
    run_frame(1'b1, 1'b1, FE, "realigned");
    set_words(64'hCAFE_0123_4567_BEEF);
    run_frame(1'b1, 1'b0, FE, "after early");
    // R9: missing sync, free-running wrap keeps timing
    set_words(64'h7654_3210_FEDC_BA98);
    run_frame(1'b0, 1'b1, FE, "missing sync");
    set_words(64'h0BAD_CAFE_F00D_D00D);
    run_frame(1'b1, 1'b0, FE, "after missing");
    summary();
  end
endmodule